// File: doc/BRIEF.md
# Byte-Select Asynchronous SRAM Controller

This block connects a simple single-request port inside the chip to an external asynchronous SRAM with a 16-bit data bus and separate active-low upper-byte and lower-byte select pins. A request carries a direction, an address, 16 bits of write data and a 2-bit byte mask. It is accepted when the controller is idle. The controller then runs one access through fixed phases: a single address-setup cycle, a strobe phase of one cycle plus a programmable number of wait cycles, a programmable hold phase of 0 to 3 cycles, and a final cycle that pulses a completion flag.

A mode input chooses which pin times a write. With the mode cleared (the reset default), the byte selects act as the write strobes. They pulse only during the strobe phase, on writes and also on reads. With the mode set, the byte selects stay low for the whole access and the read/write line pulses low during the strobe phase as the write enable. In both modes the data bus stays driven through the hold phase, so the hold count sets the data hold time after the strobe ends.

The mode, wait count and hold count are sampled together with the request. Changing them during an access has no effect on that access.

Top module: `bsel_sram_if`

## Requirements
- R1: While reset is held, and in idle after it, mem_cs_n, mem_rw_n, mem_rd_n, mem_ub_n and mem_lb_n are high, mem_dq_oe and rsp_done are low, req_ready is high and rsp_rdata is zero.
- R2: With an accept at clock edge E0, wait count W and hold count H, rsp_done is high for exactly the one cycle after edge E0+2+W+H. req_ready is low from E0 until edge E0+3+W+H and high again after it.
- R3: mem_cs_n is low from the setup cycle through the last hold cycle, and high in the done cycle and in idle.
- R4: Mode 0 (cfg_rw_strobe=0): on a write, mem_ub_n is low only in strobe cycles and only when mask bit 1 is set. mem_lb_n behaves the same for mask bit 0. mem_rw_n is low from setup through hold.
- R5: On a read in either mode, mem_rw_n stays high and mem_rd_n is low exactly in the strobe cycles. The byte selects follow the mask as on a write in the same mode: strobe cycles only in mode 0, setup through hold in mode 1.
- R6: Mode 1 (cfg_rw_strobe=1): on a write, the byte selects for the masked bytes are low from setup through hold, and mem_rw_n is low only in the strobe cycles.
- R7: mem_dq_oe is high only on writes, from setup through the last hold cycle. While it is high, mem_dq_out equals the request write data.
- R8: A read captures mem_dq_in at the clock edge that ends the last strobe cycle. rsp_rdata shows that value from then on, and writes leave it unchanged.
- R9: req_valid is ignored while req_ready is low. The running access keeps its address, data and pin timing.
- R10: cfg_rw_strobe, cfg_wait and cfg_hold are sampled at accept. Changes made during an access do not alter its timing.
- R11: mem_addr equals the request address from setup through hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte mask, bit 1 upper, bit 0 lower |
| cfg_rw_strobe | input | 1 | 0: byte selects strobe; 1: read/write line strobes |
| cfg_wait | input | WAIT_W | Extra strobe cycles |
| cfg_hold | input | 2 | Hold cycles after strobe |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Last captured read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rw_n | output | 1 | Read/write line, low = write |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_ub_n | output | 1 | Upper byte select, active low |
| mem_lb_n | output | 1 | Lower byte select, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | 16 | Data driven to memory |
| mem_dq_oe | output | 1 | Data bus output enable |
| mem_dq_in | input | 16 | Data from memory |

## Verification
Every pin is compared in each cycle k after the accept edge. Setup is k=0, strobe is 1..1+W, hold follows, done falls at k=2+W+H and idle returns at k=3+W+H. All of these follow from the counts latched at accept. The bench drives the true read value on mem_dq_in only in cycle k=1+W and its complement in every other cycle, so a capture one cycle early or late shows up in rsp_rdata at the done cycle. Request and configuration inputs are scrambled during the access to show that both are ignored. Inputs change at the falling edge and outputs are sampled there, half a cycle clear of the edge that moves the state.

// File: rtl/bsel_sram_pkg.sv
// Shared types for the byte-select SRAM controller.
package bsel_sram_pkg;

    // Access phases, walked in this order by the sequencer.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_STROBE = 3'd2,
        PH_HOLD   = 3'd3,
        PH_DONE   = 3'd4
    } phase_t;

    // Per-access control latched at accept.
    typedef struct packed {
        logic       wr;
        logic [1:0] mask;
        logic       rw_strobe;
    } acc_ctl_t;

endpackage

// File: rtl/bsel_sram_seq.sv
// Phase sequencer: walks IDLE -> SETUP -> STROBE (1+wait) -> HOLD (hold)
// -> DONE -> IDLE. Assumes wait_q/hold_q are stable from the cycle after
// start until the access ends (the top latches them at accept).
module bsel_sram_seq
    import bsel_sram_pkg::*;
#(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WAIT_W-1:0] wait_q,
    input  logic [1:0]        hold_q,
    output phase_t            phase,
    output logic              last_strobe
);

    localparam int CNT_W = (WAIT_W > 2) ? WAIT_W : 2;

    logic [CNT_W-1:0] cnt;

    // Last strobe cycle flag, used for read capture.
    always_comb last_strobe = (phase == PH_STROBE) && (cnt == '0);

    // Phase register and down-counter for strobe and hold lengths.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) phase <= PH_SETUP;
                end
                PH_SETUP: begin
                    phase <= PH_STROBE;
                    cnt   <= CNT_W'(wait_q);
                end
                PH_STROBE: begin
                    if (cnt == '0) begin
                        if (hold_q == 2'd0) begin
                            phase <= PH_DONE;
                        end else begin
                            phase <= PH_HOLD;
                            cnt   <= CNT_W'(hold_q - 2'd1);
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (cnt == '0) phase <= PH_DONE;
                    else           cnt   <= cnt - 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R2: completion lasts exactly one cycle.
    p_done_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DONE) |=> (phase == PH_IDLE));

    // R9: an access can only begin from idle.
    p_setup_from_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |=> (phase != PH_SETUP));

    // R2: hold is never entered when no hold cycles were requested.
    p_hold_needs_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_STROBE && cnt == '0 && hold_q == 2'd0) |=> (phase == PH_DONE));

endmodule

// File: rtl/bsel_sram_pins.sv
// Pin decoder: turns the phase and latched access control into the memory
// strobes. Assumes ctl is stable across the access. Outputs are decoded
// from registered state only.
module bsel_sram_pins
    import bsel_sram_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  phase_t   phase,
    input  acc_ctl_t ctl,
    output logic     cs_n,
    output logic     rw_n,
    output logic     rd_n,
    output logic     ub_n,
    output logic     lb_n,
    output logic     dq_oe
);

    logic active;
    logic strobe;
    logic bs_on;
    logic we_on;

    // Phase windows shared by all pins.
    always_comb begin
        active = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
        strobe = (phase == PH_STROBE);
    end

    // Mode select: which window the byte selects and write enable use.
    always_comb begin
        bs_on = ctl.rw_strobe ? active : strobe;
        we_on = ctl.rw_strobe ? strobe : active;
    end

    // Active-low pin drive.
    always_comb begin
        cs_n  = !active;
        ub_n  = !(bs_on && ctl.mask[1]);
        lb_n  = !(bs_on && ctl.mask[0]);
        rw_n  = !(ctl.wr && we_on);
        rd_n  = !(!ctl.wr && strobe);
        dq_oe = ctl.wr && active;
    end

    // R7: never drive the bus while the memory is asked to drive it.
    p_no_bus_fight_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(dq_oe && !rd_n));

    // R6: in mode 1 the byte selects do not toggle inside the strobe.
    p_bs_steady_mode1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.rw_strobe && phase == PH_STROBE) |-> $stable({ub_n, lb_n}));

    // R4: in mode 0 the byte selects stay idle during setup.
    p_bs_quiet_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.rw_strobe && phase == PH_SETUP) |-> (ub_n && lb_n));

    // R3: chip select is released once the access completes.
    p_cs_off_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DONE) |-> (cs_n && rw_n && rd_n));

endmodule

// File: rtl/bsel_sram_if.sv
// Top: byte-select asynchronous SRAM controller. Latches one request plus
// its configuration at accept, sequences the access and captures read
// data. Assumes the memory meets its timing within the programmed phases.
module bsel_sram_if
    import bsel_sram_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic [1:0]        req_mask,
    input  logic              cfg_rw_strobe,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic [1:0]        cfg_hold,
    output logic              rsp_done,
    output logic [15:0]       rsp_rdata,
    output logic              mem_cs_n,
    output logic              mem_rw_n,
    output logic              mem_rd_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [15:0]       mem_dq_in
);

    phase_t            phase;
    logic              last_strobe;
    logic              accept;
    acc_ctl_t          ctl_q;
    logic [ADDR_W-1:0] addr_q;
    logic [15:0]       wdata_q;
    logic [WAIT_W-1:0] wait_q;
    logic [1:0]        hold_q;

    // Handshake: only idle takes a request.
    always_comb begin
        req_ready = (phase == PH_IDLE);
        accept    = req_valid && req_ready;
        rsp_done  = (phase == PH_DONE);
    end

    // Request and configuration latch, loaded only on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            wait_q  <= '0;
            hold_q  <= '0;
        end else if (accept) begin
            ctl_q.wr        <= req_write;
            ctl_q.mask      <= req_mask;
            ctl_q.rw_strobe <= cfg_rw_strobe;
            addr_q          <= req_addr;
            wdata_q         <= req_wdata;
            wait_q          <= cfg_wait;
            hold_q          <= cfg_hold;
        end
    end

    // Read capture on the last strobe cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                        rsp_rdata <= '0;
        else if (last_strobe && !ctl_q.wr) rsp_rdata <= mem_dq_in;
    end

    always_comb begin
        mem_addr   = addr_q;
        mem_dq_out = wdata_q;
    end

    bsel_sram_seq #(.WAIT_W(WAIT_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept),
        .wait_q      (wait_q),
        .hold_q      (hold_q),
        .phase       (phase),
        .last_strobe (last_strobe)
    );

    bsel_sram_pins u_pins (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase),
        .ctl   (ctl_q),
        .cs_n  (mem_cs_n),
        .rw_n  (mem_rw_n),
        .rd_n  (mem_rd_n),
        .ub_n  (mem_ub_n),
        .lb_n  (mem_lb_n),
        .dq_oe (mem_dq_oe)
    );

    // R9: the latched address cannot move while an access runs.
    p_addr_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !rsp_done) |=> $stable(mem_addr));

    // R8: read data only changes at the end of a strobe phase.
    p_rdata_only_at_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_STROBE) |=> $stable(rsp_rdata));

endmodule

// File: tb/bsel_sram_if_tb.sv
module bsel_sram_if_tb;

    localparam int AW = 20;
    localparam int WW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_wdata = '0;
    logic [1:0]    req_mask = '0;
    logic          cfg_rw_strobe = 1'b0;
    logic [WW-1:0] cfg_wait = '0;
    logic [1:0]    cfg_hold = '0;
    logic          rsp_done;
    logic [15:0]   rsp_rdata;
    logic          mem_cs_n, mem_rw_n, mem_rd_n, mem_ub_n, mem_lb_n, mem_dq_oe;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_dq_out;
    logic [15:0]   mem_dq_in = '0;

    int vectors = 0;
    int fails   = 0;
    logic [15:0] last_rd = '0;

    always #2 clk = ~clk;

    bsel_sram_if #(.ADDR_W(AW), .WAIT_W(WW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .cfg_rw_strobe(cfg_rw_strobe), .cfg_wait(cfg_wait),
        .cfg_hold(cfg_hold), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_cs_n(mem_cs_n), .mem_rw_n(mem_rw_n), .mem_rd_n(mem_rd_n),
        .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Expected active-low byte select for one byte lane.
    function automatic logic exp_bs_n(input bit mode, input bit act, input bit stb, input bit m);
        return !((mode ? act : stb) && m);
    endfunction

    function automatic logic exp_rw_n(input bit wr, input bit mode, input bit act, input bit stb);
        return !(wr && (mode ? stb : act));
    endfunction

    // One access, checked every cycle from setup (k=0) to idle (k=3+w+h).
    task automatic run_access(input bit wr, input logic [AW-1:0] a, input logic [15:0] d,
                              input logic [1:0] m, input bit mode, input int w,
                              input int h, input bit noisy);
        logic [15:0] rd_val;
        int last;
        rd_val = 16'($urandom);
        last   = 3 + w + h;
        @(negedge clk);
        chk("R2 ready before accept", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        cfg_rw_strobe = mode; cfg_wait = WW'(w); cfg_hold = 2'(h);
        for (int k = 0; k <= last; k++) begin
            bit act, stb;
            @(negedge clk);
            act = (k <= 1 + w + h);
            stb = (k >= 1) && (k <= 1 + w);
            if (noisy && k < 2 + w + h) begin
                // R9 / R10: scramble request and config while busy
                req_valid = 1'b1; req_write = 1'($urandom); req_addr = AW'($urandom);
                req_wdata = 16'($urandom); req_mask = 2'($urandom);
                cfg_rw_strobe = 1'($urandom); cfg_wait = WW'($urandom); cfg_hold = 2'($urandom);
            end else begin
                req_valid = 1'b0;
            end
            mem_dq_in = (k == 1 + w) ? rd_val : ~rd_val;
            chk("R3 cs_n", {31'd0, mem_cs_n}, {31'd0, !act});
            chk(wr ? (mode ? "R6 ub_n" : "R4 ub_n") : "R5 ub_n",
                {31'd0, mem_ub_n}, {31'd0, exp_bs_n(mode, act, stb, m[1])});
            chk(wr ? (mode ? "R6 lb_n" : "R4 lb_n") : "R5 lb_n",
                {31'd0, mem_lb_n}, {31'd0, exp_bs_n(mode, act, stb, m[0])});
            chk(wr ? (mode ? "R6 rw_n" : "R4 rw_n") : "R5 rw_n",
                {31'd0, mem_rw_n}, {31'd0, exp_rw_n(wr, mode, act, stb)});
            chk("R5 rd_n", {31'd0, mem_rd_n}, {31'd0, !(!wr && stb)});
            chk("R7 dq_oe", {31'd0, mem_dq_oe}, {31'd0, wr && act});
            chk("R2 done", {31'd0, rsp_done}, {31'd0, k == 2 + w + h});
            chk("R2 ready", {31'd0, req_ready}, {31'd0, k == last});
            if (act) chk("R11 addr", 32'(mem_addr), 32'(a));
            if (act && wr) chk("R7 dq_out", 32'(mem_dq_out), 32'(d));
            if (k == 2 + w + h) begin
                if (!wr) last_rd = rd_val;
                chk("R8 rdata", 32'(rsp_rdata), 32'(last_rd));
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog act=timeout exp=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 cs_n", {31'd0, mem_cs_n}, 32'd1);
        chk("R1 rw_n", {31'd0, mem_rw_n}, 32'd1);
        chk("R1 rd_n", {31'd0, mem_rd_n}, 32'd1);
        chk("R1 bs_n", {30'd0, mem_ub_n, mem_lb_n}, 32'd3);
        chk("R1 dq_oe", {31'd0, mem_dq_oe}, 32'd0);
        chk("R1 done", {31'd0, rsp_done}, 32'd0);
        chk("R1 ready", {31'd0, req_ready}, 32'd1);
        chk("R1 rdata", 32'(rsp_rdata), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle cs_n", {31'd0, mem_cs_n}, 32'd1);

        // Directed corners
        run_access(1'b1, 20'h00011, 16'hA55A, 2'b11, 1'b0, 0, 0, 1'b0);   // R4 minimum
        run_access(1'b1, 20'hFFFFF, 16'h1234, 2'b10, 1'b1, 15, 3, 1'b0);  // R6 maximum
        run_access(1'b0, 20'h00ABC, 16'h0000, 2'b01, 1'b0, 0, 0, 1'b0);   // R5 / R8
        run_access(1'b0, 20'h12345, 16'h0000, 2'b11, 1'b1, 3, 2, 1'b1);   // R5 / R9 / R10
        run_access(1'b1, 20'h54321, 16'hFFFF, 2'b01, 1'b0, 2, 3, 1'b1);   // R8 held across write
        run_access(1'b1, 20'h0F0F0, 16'h8001, 2'b00, 1'b1, 1, 1, 1'b0);   // empty mask

        // Constrained random mix
        for (int i = 0; i < 300; i++) begin
            int w;
            w = ($urandom % 4 == 0) ? int'($urandom % 16) : int'($urandom % 3);
            run_access(1'($urandom), AW'($urandom), 16'($urandom), 2'($urandom),
                       1'($urandom), w, int'($urandom % 4), 1'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule